// File: doc/BRIEF.md
# Memory Type Register Write Checker

This block screens a proposed 64-bit write to one of the memory-type control registers before any storage is updated. Each request carries a register index, the 64-bit data word and the physical address width in use. The block classifies the index and checks the data against the rules for that register class. It then returns a verdict: the write is legal, or it is refused. A refused write to a variable-range register whose data sets address bits that must be zero is also flagged as a fault. The requester uses the fault flag to raise a protection exception instead of simply dropping the write.

Five register classes are covered: the default-type register, the eleven fixed-range registers, the page attribute register, and the variable base/mask pairs. The block also recognises the read-only capability register and returns its fixed read value on the response. Requests enter through a valid/ready port. One response per accepted request leaves through a second valid/ready port one clock later. A request is taken on a cycle where `in_valid` and `in_ready` are both high. A response is consumed on a cycle where `out_valid` and `out_ready` are both high. While the response is not consumed, it is held unchanged and no new request is taken.

Top module: `mtype_wr_check`

## Requirements
- R1: Each type byte is tested as a value 0..255. For a range-type byte the legal values are 0, 1, 4, 5 and 6. For a page-attribute byte the legal values are 0, 1, 4, 5, 6 and 7. Values 2, 3 and anything above 7 are never legal, and 7 is legal only as a page attribute.
- R2: A write to the page attribute register (index 0x277) is accepted only if all eight bytes of the data word are legal page-attribute values.
- R3: A write to a fixed-range register (indices 0x250, 0x258, 0x259 and 0x268 through 0x26F) is accepted only if all eight data bytes are legal range types. Neighbouring indices such as 0x25A are not fixed-range registers.
- R4: A write to the default-type register (index 0x2FF) is refused if any bit outside mask 0xCFF is set. It is also refused if data bits 7:0 are not a legal range type. Otherwise it is accepted. No fault is raised.
- R5: Index 0x200 + 2k, for k below NUM_VAR, is a variable base register. If bits 7:0 are not a legal range type, the write is refused without a fault. Otherwise, if any of bits 11:8 or any bit at or above the effective address width is set, the write is refused and the fault flag is raised. Otherwise it is accepted.
- R6: Index 0x201 + 2k, for k below NUM_VAR, is a variable mask register. If any of bits 10:0 or any bit at or above the effective address width is set, the write is refused and the fault flag is raised. Otherwise it is accepted.
- R7: The effective address width is `in_paw` clamped to the range PAW_MIN..PAW_MAX (default 36..52).
- R8: Index 0x0FE is the capability register. Its response has `out_cap` high, `out_rdata` equal to 0x500 ORed with NUM_VAR, and accept and fault both low. For every other index `out_cap` is low and `out_rdata` is zero.
- R9: Any index outside the recognised set is refused without a fault. This includes 0x200 + 2·NUM_VAR and above.
- R10: `in_ready` equals `!out_valid || out_ready`. An accepted request produces `out_valid` on the next cycle. A response is held stable while `out_ready` is low.
- R11: During and right after reset, `out_valid` is low.
- R12: `out_fault` is never high together with `out_accept`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_index | input | 32 | Register index of the proposed write |
| in_data | input | 64 | Proposed write data |
| in_paw | input | 6 | Physical address width in bits |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response this cycle |
| out_accept | output | 1 | Write is legal |
| out_fault | output | 1 | Reserved address bit set on a variable register write |
| out_cap | output | 1 | Index named the capability register |
| out_rdata | output | 64 | Capability read value, zero otherwise |

## Verification
Each verdict is due exactly one cycle after its request is taken, and it stays on the output pins until the cycle it is consumed. The bench models this with a one-deep queue of expected responses. The queue advances at the same clock edges the handshake rules name. The bench compares the queue head and `out_valid` against the pins midway through every clock period. `in_ready` is compared against the model shortly after each drive. A phase with random back-pressure checks that a stalled verdict does not drift and that no request is taken while it waits.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_CAP,
    CLS_DEFT,
    CLS_FIXED,
    CLS_ATTR,
    CLS_VBASE,
    CLS_VMASK
  } reg_class_e;

  localparam int unsigned IDX_W      = 32;
  localparam int unsigned LANES      = 8;
  localparam int unsigned LANE_W     = 8;
  localparam int unsigned DATA_W     = LANES * LANE_W;

  localparam logic [IDX_W-1:0] IDX_CAP    = 32'h0000_00FE;
  localparam logic [IDX_W-1:0] IDX_VAR0   = 32'h0000_0200;
  localparam logic [IDX_W-1:0] IDX_FIX64  = 32'h0000_0250;
  localparam logic [IDX_W-1:0] IDX_FIX16A = 32'h0000_0258;
  localparam logic [IDX_W-1:0] IDX_FIX16B = 32'h0000_0259;
  localparam logic [IDX_W-1:0] IDX_FIX4LO = 32'h0000_0268;
  localparam logic [IDX_W-1:0] IDX_FIX4HI = 32'h0000_026F;
  localparam logic [IDX_W-1:0] IDX_ATTR   = 32'h0000_0277;
  localparam logic [IDX_W-1:0] IDX_DEFT   = 32'h0000_02FF;

  localparam logic [DATA_W-1:0] DEFT_KEEP = 64'h0000_0000_0000_0CFF;
  localparam logic [DATA_W-1:0] BASE_RSV  = 64'h0000_0000_0000_0F00;
  localparam logic [DATA_W-1:0] MASK_RSV  = 64'h0000_0000_0000_07FF;
  localparam logic [DATA_W-1:0] CAP_FLAGS = 64'h0000_0000_0000_0500;

  // Bit t set: encoding t legal. Range types take 0,1,4,5,6; attributes add 7.
  localparam logic [7:0] RANGE_SET = 8'h73;
  localparam logic [7:0] ATTR_SET  = 8'hF3;

endpackage

// File: rtl/mtc_decode.sv
module mtc_decode
  import mtc_pkg::*;
#(
  parameter int unsigned NUM_VAR = 8
) (
  input  logic [IDX_W-1:0] idx,
  output reg_class_e       cls
);
  localparam logic [IDX_W-1:0] VAR_SPAN = IDX_W'(2 * NUM_VAR);

  logic [IDX_W-1:0] var_off;
  logic             in_var;
  logic             is_fixed;

  assign var_off  = idx - IDX_VAR0;
  assign in_var   = (idx >= IDX_VAR0) && (var_off < VAR_SPAN);
  assign is_fixed = (idx == IDX_FIX64) || (idx == IDX_FIX16A) || (idx == IDX_FIX16B) ||
                    ((idx >= IDX_FIX4LO) && (idx <= IDX_FIX4HI));

  always_comb begin
    cls = CLS_NONE;
    if (idx == IDX_CAP)       cls = CLS_CAP;
    else if (idx == IDX_DEFT) cls = CLS_DEFT;
    else if (idx == IDX_ATTR) cls = CLS_ATTR;
    else if (is_fixed)        cls = CLS_FIXED;
    else if (in_var)          cls = var_off[0] ? CLS_VMASK : CLS_VBASE;
  end
endmodule

// File: rtl/mtc_lane_check.sv
module mtc_lane_check
  import mtc_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic              attr_mode,
  output logic              all_ok,
  output logic              low_ok
);
  logic [LANES-1:0] lane_ok;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] t;
    logic [7:0]        legal_set;
    assign t         = data[g*LANE_W +: LANE_W];
    assign legal_set = attr_mode ? ATTR_SET : RANGE_SET;
    assign lane_ok[g] = (t < LANE_W'(8)) && legal_set[t[2:0]];
  end

  assign all_ok = &lane_ok;
  // Low lane is always judged as a range type (default and base registers).
  assign low_ok = (data[LANE_W-1:0] < LANE_W'(8)) && RANGE_SET[data[2:0]];
endmodule

// File: rtl/mtc_resv_check.sv
module mtc_resv_check
  import mtc_pkg::*;
#(
  parameter int unsigned PAW_MIN = 36,
  parameter int unsigned PAW_MAX = 52
) (
  input  logic [DATA_W-1:0] data,
  input  logic [5:0]        paw,
  input  logic              is_base,
  output logic              resv_hit
);
  localparam logic [5:0] LO = 6'(PAW_MIN);
  localparam logic [5:0] HI = 6'(PAW_MAX);

  logic [5:0]        eff_paw;
  logic [DATA_W-1:0] high_rsv;
  logic [DATA_W-1:0] all_rsv;

  always_comb begin
    if (paw < LO)      eff_paw = LO;
    else if (paw > HI) eff_paw = HI;
    else               eff_paw = paw;
  end

  assign high_rsv = {DATA_W{1'b1}} << eff_paw;
  assign all_rsv  = high_rsv | (is_base ? BASE_RSV : MASK_RSV);
  assign resv_hit = |(data & all_rsv);
endmodule

// File: rtl/mtype_wr_check.sv
module mtype_wr_check
  import mtc_pkg::*;
#(
  parameter int unsigned NUM_VAR = 8,
  parameter int unsigned PAW_MIN = 36,
  parameter int unsigned PAW_MAX = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_index,
  input  logic [DATA_W-1:0] in_data,
  input  logic [5:0]        in_paw,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_accept,
  output logic              out_fault,
  output logic              out_cap,
  output logic [DATA_W-1:0] out_rdata
);
  localparam logic [DATA_W-1:0] CAP_VALUE = CAP_FLAGS | DATA_W'(NUM_VAR);

  reg_class_e cls;
  logic       all_ok, low_ok, resv_hit;
  logic       nx_accept, nx_fault, nx_cap;
  logic       take;

  mtc_decode #(.NUM_VAR(NUM_VAR)) u_dec (
    .idx (in_index),
    .cls (cls)
  );

  mtc_lane_check u_lanes (
    .data      (in_data),
    .attr_mode (cls == CLS_ATTR),
    .all_ok    (all_ok),
    .low_ok    (low_ok)
  );

  mtc_resv_check #(.PAW_MIN(PAW_MIN), .PAW_MAX(PAW_MAX)) u_rsv (
    .data     (in_data),
    .paw      (in_paw),
    .is_base  (cls == CLS_VBASE),
    .resv_hit (resv_hit)
  );

  always_comb begin
    nx_accept = 1'b0;
    nx_fault  = 1'b0;
    nx_cap    = 1'b0;
    unique case (cls)
      CLS_CAP:   nx_cap    = 1'b1;
      CLS_DEFT:  nx_accept = ((in_data & ~DEFT_KEEP) == '0) && low_ok;
      CLS_FIXED,
      CLS_ATTR:  nx_accept = all_ok;
      CLS_VBASE: begin
        nx_accept = low_ok && !resv_hit;
        nx_fault  = low_ok && resv_hit;
      end
      CLS_VMASK: begin
        nx_accept = !resv_hit;
        nx_fault  = resv_hit;
      end
      default: ;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_accept <= 1'b0;
      out_fault  <= 1'b0;
      out_cap    <= 1'b0;
      out_rdata  <= '0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_accept <= nx_accept;
      out_fault  <= nx_fault;
      out_cap    <= nx_cap;
      out_rdata  <= nx_cap ? CAP_VALUE : '0;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R10
  resp_follows_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_accept) &&
                                   $stable(out_fault) && $stable(out_cap) && $stable(out_rdata)));

  // R12
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_fault && out_accept));

  // R8
  cap_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cap) |-> (!out_accept && !out_fault && out_rdata == CAP_VALUE));

  // R5
  fault_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cls != CLS_VBASE && cls != CLS_VMASK) |=> !out_fault);

  // R11
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);
endmodule

// File: tb/tb_mtype_wr_check.sv
`timescale 1ns/1ps
module tb_mtype_wr_check;
  localparam int NVAR = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_index = '0;
  logic [63:0] in_data = '0;
  logic [5:0]  in_paw = 6'd36;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_accept, out_fault, out_cap;
  logic [63:0] out_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit rnd_ready = 0;
  bit last_taken;

  logic [66:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  mtype_wr_check #(.NUM_VAR(NVAR), .PAW_MIN(36), .PAW_MAX(52)) dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_index, .in_data, .in_paw,
    .out_valid, .out_ready, .out_accept, .out_fault, .out_cap, .out_rdata
  );

  function automatic bit byte_ok(int b, bit attr);
    case (b)
      0, 1, 4, 5, 6: return 1;
      7:             return attr;
      default:       return 0;
    endcase
  endfunction

  // Behavioural reference: returns {accept, fault, cap, rdata}
  function automatic logic [66:0] model(logic [31:0] idx, logic [63:0] d, int paw);
    bit acc = 0, flt = 0, cap = 0;
    logic [63:0] rd = 0;
    int w = (paw < 36) ? 36 : (paw > 52 ? 52 : paw);
    bit hi_set = 0;
    for (int b = w; b < 64; b++) if (d[b]) hi_set = 1;
    if (idx == 32'hFE) begin
      cap = 1; rd = 64'h500 + NVAR;
    end else if (idx == 32'h277) begin
      acc = 1;
      for (int i = 0; i < 8; i++) if (!byte_ok(int'(d[i*8 +: 8]), 1)) acc = 0;
    end else if (idx == 32'h250 || idx == 32'h258 || idx == 32'h259 ||
                 (idx >= 32'h268 && idx <= 32'h26F)) begin
      acc = 1;
      for (int i = 0; i < 8; i++) if (!byte_ok(int'(d[i*8 +: 8]), 0)) acc = 0;
    end else if (idx == 32'h2FF) begin
      acc = byte_ok(int'(d[7:0]), 0) && (d[63:12] == 0) && (d[9:8] == 0);
    end else if (idx >= 32'h200 && idx < 32'h200 + 2 * NVAR) begin
      if (idx[0] == 1'b0) begin
        if (byte_ok(int'(d[7:0]), 0)) begin
          flt = hi_set || (d[11:8] != 0);
          acc = !flt;
        end
      end else begin
        flt = hi_set || (d[10:0] != 0);
        acc = !flt;
      end
    end
    return {acc, flt, cap, rd};
  endfunction

  task automatic fail_line(string tag, string what, logic [63:0] act, logic [63:0] exp);
    bad++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  // One clock: check in_ready after the drive, then model the edge and compare.
  task automatic tick(string tag);
    bit pre_v, rdy;
    #1;
    total++;
    pre_v = exp_q.size() > 0;
    if (in_ready !== (!pre_v || out_ready)) fail_line("R10", "in_ready", 64'(in_ready), 64'(!pre_v || out_ready));
    @(negedge clk);
    rdy = !pre_v || out_ready;
    if (pre_v && out_ready) begin void'(exp_q.pop_front()); void'(tag_q.pop_front()); end
    last_taken = in_valid && rdy;
    if (last_taken) begin exp_q.push_back(model(in_index, in_data, int'(in_paw))); tag_q.push_back(tag); end
    total++;
    if (out_valid !== (exp_q.size() > 0)) fail_line("R10", "out_valid", 64'(out_valid), 64'(exp_q.size() > 0));
    if (exp_q.size() > 0) begin
      logic [66:0] e = exp_q[0];
      total++;
      if ({out_accept, out_fault, out_cap} !== e[66:64] || out_rdata !== e[63:0])
        fail_line(tag_q[0], "verdict", {out_accept, out_fault, out_cap, out_rdata[59:0]},
                  {e[66:64], e[59:0]});
    end
    if (rnd_ready) out_ready = ($urandom % 3) != 0;
  endtask

  task automatic send(string tag, logic [31:0] idx, logic [63:0] d, int paw);
    in_valid = 1; in_index = idx; in_data = d; in_paw = 6'(paw);
    do tick(tag); while (!last_taken);
    in_valid = 0;
  endtask

  initial begin
    #20000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: idle during reset
    total++;
    if (out_valid !== 1'b0) fail_line("R11", "out_valid in reset", 64'(out_valid), 0);
    rst_n = 1;
    tick("R11");

    // R1 R2: attribute bytes
    send("R2", 32'h277, 64'h0007_0605_0401_0000, 36);
    send("R2", 32'h277, 64'h0707_0707_0707_0707, 36);
    send("R1", 32'h277, 64'h0000_0200_0000_0000, 36);
    send("R1", 32'h277, 64'h0300_0000_0000_0000, 36);
    send("R1", 32'h277, 64'h0000_0000_0000_0008, 36);
    // R3: fixed ranges
    send("R3", 32'h250, 64'h0606_0606_0606_0606, 36);
    send("R3", 32'h259, 64'h0505_0505_0404_0100, 36);
    send("R3", 32'h26F, 64'h0000_0000_0700_0000, 36);
    send("R1", 32'h268, 64'h0602_0000_0000_0000, 36);
    send("R9", 32'h25A, 64'h0, 36);
    // R4: default type
    send("R4", 32'h2FF, 64'hC06, 36);
    send("R4", 32'h2FF, 64'hC07, 36);
    send("R4", 32'h2FF, 64'h1006, 36);
    send("R4", 32'h2FF, 64'h106, 36);
    // R5: variable base
    send("R5", 32'h200, 64'h0000_000F_FFFF_F006, 36);
    send("R5", 32'h200, 64'h0000_0010_0000_0006, 36);
    send("R5", 32'h202, 64'h0000_0000_0000_0107, 36);
    send("R5", 32'h204, 64'h0000_0000_0000_0106, 36);
    send("R5", 32'h20E, 64'h0000_0100_0000_0007, 36);
    // R6: variable mask
    send("R6", 32'h201, 64'h0000_000F_FFFF_F800, 36);
    send("R6", 32'h201, 64'h0000_000F_FFFF_F801, 36);
    send("R6", 32'h20F, 64'h0004_0000_0000_0800, 52);
    send("R6", 32'h20F, 64'h0004_0000_0000_0800, 48);
    // R7: width clamping
    send("R7", 32'h203, 64'h0000_0100_0000_0800, 20);
    send("R7", 32'h203, 64'h0000_0008_0000_0800, 20);
    send("R7", 32'h203, 64'h0010_0000_0000_0800, 60);
    // R8 R9: capability and unknown indices
    send("R8", 32'hFE, 64'hFFFF, 36);
    send("R9", 32'h210, 64'h0, 36);
    send("R9", 32'h1FF, 64'h0, 36);
    tick("R10");

    // R10 R12: random traffic with back-pressure
    rnd_ready = 1;
    for (int n = 0; n < 300; n++) begin
      logic [31:0] pick [10] = '{32'hFE, 32'h200, 32'h201, 32'h20F, 32'h210,
                                 32'h250, 32'h26C, 32'h277, 32'h2FF, 32'h2FE};
      logic [63:0] d;
      d = {$urandom, $urandom};
      if ($urandom % 2) for (int i = 0; i < 8; i++) d[i*8 +: 8] = 8'($urandom % 8);
      if ($urandom % 2) d[63:36] = '0;
      send("R10", pick[$urandom % 10], d, 30 + int'($urandom % 30));
    end
    rnd_ready = 0;
    out_ready = 1;
    repeat (3) tick("R10");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule